// File: doc/BRIEF.md
# Segmented Address Generation Unit

This block forms the physical bus address for one memory access. It first adds up to three offset components: a base register, an index register scaled by 1, 2, 4 or 8, and a displacement. It then adds a segment base to that offset to get a 32-bit linear address. In real mode the segment base is the 16-bit selector moved up by four bit positions. In protected mode the segment base is read from an eight-entry descriptor base table, which is loaded through a separate write port. A final stage applies paging. With paging off, the physical address is the linear address. With paging on, a caller-supplied page frame replaces the upper twenty bits, and the low twelve bits pass through unchanged.

The bus side presents a word address (physical bits 31..2) and four active-low byte enables. An access of one, two or four bytes that runs past the end of a 4-byte word is split into two bus beats. The beats come on consecutive cycles, lower word first. A small state machine drives the beats. Its states are IDLE (nothing presented), ONE (a single beat or the first half of a split), TWO (the second half of a split) and FLT (a one-cycle fault pulse). On an accepted request, every state moves to FLT if the request faults and to ONE if it does not. With no accepted request, every state moves to IDLE, except that ONE moves to TWO whenever the beat it presents is split.

Top module: `agu_top`

## Requirements
- R1: During and after reset, bus_valid and bus_fault are 0, bus_be_n is 4'hF, bus_addr is 0, bus_split is 0 and req_ready is 1. All descriptor table entries are marked unloaded.
- R2: The offset is (base_en ? base : 0) + (index_en ? index << scale : 0) + disp, taken modulo 2^32. The scale code 0/1/2/3 selects a factor of 1/2/4/8.
- R3: When prot is 0, the linear address is {selector, 4'b0000} zero-extended to 32 bits plus the offset, modulo 2^32.
- R4: When prot is 1, the linear address is table entry selector[5:3] plus the offset, modulo 2^32. A write through tbl_we loads the entry and marks it loaded at the clock edge. A request accepted at that same edge still sees the old entry.
- R5: A request with prot 1 that uses an unloaded entry raises bus_fault for exactly one cycle, one cycle after acceptance. No bus beat is produced for it. A request with prot 0 never faults.
- R6: With paging 0, the physical address equals the linear address. With paging 1, it is {frame, linear[11:0]}.
- R7: A request is accepted in a cycle where req_valid and req_ready are both 1. Its first beat appears in the next cycle with bus_valid 1 and bus_addr equal to physical[31:2]. When bus_valid is 0, bus_addr is 0 and bus_be_n is 4'hF.
- R8: The size code 0/1/2/3 means 1/2/4/4 bytes. The access covers byte lanes linear[1:0] through linear[1:0]+bytes-1. bus_be_n[n] is 0 exactly for the covered lanes n that are below 4.
- R9: If the covered lanes go past lane 3, the access is split. The first beat carries the lanes below 4. In the next cycle a second beat follows with bus_addr one higher (modulo 2^30), carrying the lanes that spilled over, starting at lane 0. bus_split is 1 on both beats, and req_ready is 0 while the first beat is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_prot | input | 1 | 1 = protected-mode translation, 0 = real mode |
| req_paging | input | 1 | 1 = replace page frame bits |
| req_selector | input | 16 | Segment selector |
| req_base_en | input | 1 | Include base component |
| req_base | input | 32 | Base component |
| req_index_en | input | 1 | Include scaled index component |
| req_index | input | 32 | Index component |
| req_scale | input | 2 | Index shift amount (factor 1/2/4/8) |
| req_disp | input | 32 | Displacement |
| req_size | input | 2 | Access size code |
| req_frame | input | 20 | Page frame used when paging is on |
| tbl_we | input | 1 | Descriptor table write strobe |
| tbl_idx | input | 3 | Table entry to write |
| tbl_base | input | 32 | Segment base to store |
| bus_valid | output | 1 | Bus beat present |
| bus_addr | output | 30 | Word address (physical bits 31..2) |
| bus_be_n | output | 4 | Active-low byte enables, bit n = lane n |
| bus_split | output | 1 | Beat belongs to a split access |
| bus_fault | output | 1 | Unloaded descriptor used in protected mode |

## Verification
Directed real-mode requests turn each offset component on and off one at a time and sweep the scale code. This tells a missing or doubled component apart from a wrong shift. Protected-mode requests are issued around table writes, including a write and a request on the same edge. This separates correct entry selection, write timing and fault detection from one another. Every size is combined with every low address pair, so single beats and both halves of split beats are exercised, including a wrap at the top of the word address space. Both paging settings are used, so frame replacement can be told apart from pass-through. Long runs of random requests and back-to-back valid cycles then check that acceptance stalls only behind the first half of a split.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_DWALT = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ONE  = 2'd1,
        ST_TWO  = 2'd2,
        ST_FLT  = 2'd3
    } agu_state_e;

    localparam int unsigned LANES     = 4;
    localparam int unsigned LANE_BITS = 2;

endpackage

// File: rtl/agu_offset.sv
module agu_offset #(
    parameter int unsigned AW = 32
) (
    input  logic          base_en,
    input  logic [AW-1:0] base,
    input  logic          index_en,
    input  logic [AW-1:0] index,
    input  logic [1:0]    scale,
    input  logic [AW-1:0] disp,
    output logic [AW-1:0] offset
);
    logic [AW-1:0] base_term;
    logic [AW-1:0] index_term;

    always_comb begin
        base_term  = base_en ? base : '0;
        index_term = index_en ? (index << scale) : '0;
        offset     = base_term + index_term + disp;
    end
endmodule

// File: rtl/agu_desc_tbl.sv
module agu_desc_tbl #(
    parameter int unsigned AW    = 32,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_base,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_base,
    output logic          rd_loaded
);
    logic [AW-1:0] base_q   [DEPTH];
    logic [DEPTH-1:0] load_q;

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[e] <= '0;
                load_q[e] <= 1'b0;
            end else if (wr_en && (wr_idx == IW'(e))) begin
                base_q[e] <= wr_base;
                load_q[e] <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_base   = base_q[rd_idx];
        rd_loaded = load_q[rd_idx];
    end
endmodule

// File: rtl/agu_lane.sv
module agu_lane
    import agu_pkg::*;
(
    input  logic [LANE_BITS-1:0] lo_addr,
    input  logic [1:0]           size,
    output logic [LANES-1:0]     be1_n,
    output logic [LANES-1:0]     be2_n,
    output logic                 split
);
    logic [2*LANES-1:0] seed;
    logic [2*LANES-1:0] span;

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE:  seed = 8'h01;
            SZ_WORD:  seed = 8'h03;
            SZ_DWORD: seed = 8'h0F;
            SZ_DWALT: seed = 8'h0F;
        endcase
        span  = seed << lo_addr;
        be1_n = ~span[LANES-1:0];
        be2_n = ~span[2*LANES-1:LANES];
        split = |span[2*LANES-1:LANES];
    end
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter int unsigned SEL_W     = 16,
    parameter int unsigned TBL_DEPTH = 8,
    parameter int unsigned IDX_LSB   = 3,
    parameter int unsigned PAGE_BITS = 12,
    localparam int unsigned TBL_IW   = $clog2(TBL_DEPTH),
    localparam int unsigned FRAME_W  = AW - PAGE_BITS,
    localparam int unsigned WA_W     = AW - LANE_BITS,
    localparam int unsigned PAD_W    = AW - SEL_W - 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_prot,
    input  logic               req_paging,
    input  logic [SEL_W-1:0]   req_selector,
    input  logic               req_base_en,
    input  logic [AW-1:0]      req_base,
    input  logic               req_index_en,
    input  logic [AW-1:0]      req_index,
    input  logic [1:0]         req_scale,
    input  logic [AW-1:0]      req_disp,
    input  logic [1:0]         req_size,
    input  logic [FRAME_W-1:0] req_frame,
    input  logic               tbl_we,
    input  logic [TBL_IW-1:0]  tbl_idx,
    input  logic [AW-1:0]      tbl_base,
    output logic               bus_valid,
    output logic [WA_W-1:0]    bus_addr,
    output logic [LANES-1:0]   bus_be_n,
    output logic               bus_split,
    output logic               bus_fault
);
    agu_state_e state_q, state_d;

    logic [AW-1:0]    offset;
    logic [AW-1:0]    seg_base;
    logic             seg_loaded;
    logic [AW-1:0]    real_lin;
    logic [AW-1:0]    prot_lin;
    logic [AW-1:0]    lin;
    logic [AW-1:0]    phys;
    logic             fault_c;
    logic             accept;
    logic [LANES-1:0] be1_c, be2_c;
    logic             split_c;

    logic [WA_W-1:0]  addr_q;
    logic [LANES-1:0] be1_q, be2_q;
    logic             split_q;

    agu_offset #(.AW(AW)) u_offset (
        .base_en  (req_base_en),
        .base     (req_base),
        .index_en (req_index_en),
        .index    (req_index),
        .scale    (req_scale),
        .disp     (req_disp),
        .offset   (offset)
    );

    agu_desc_tbl #(.AW(AW), .DEPTH(TBL_DEPTH)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_we),
        .wr_idx    (tbl_idx),
        .wr_base   (tbl_base),
        .rd_idx    (req_selector[IDX_LSB +: TBL_IW]),
        .rd_base   (seg_base),
        .rd_loaded (seg_loaded)
    );

    always_comb begin
        real_lin = {{PAD_W{1'b0}}, req_selector, 4'b0000} + offset;
        prot_lin = seg_base + offset;
        lin      = req_prot ? prot_lin : real_lin;
        fault_c  = req_prot & ~seg_loaded;
        phys     = req_paging ? {req_frame, lin[PAGE_BITS-1:0]} : lin;
    end

    agu_lane u_lane (
        .lo_addr (lin[LANE_BITS-1:0]),
        .size    (req_size),
        .be1_n   (be1_c),
        .be2_n   (be2_c),
        .split   (split_c)
    );

    assign req_ready = !((state_q == ST_ONE) && split_q);
    assign accept    = req_valid && req_ready;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_ONE: begin
                if (split_q)      state_d = ST_TWO;
                else if (accept)  state_d = fault_c ? ST_FLT : ST_ONE;
            end
            ST_IDLE, ST_TWO, ST_FLT: begin
                if (accept)       state_d = fault_c ? ST_FLT : ST_ONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            be1_q   <= '1;
            be2_q   <= '1;
            split_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= phys[AW-1:LANE_BITS];
            be1_q   <= be1_c;
            be2_q   <= be2_c;
            split_q <= split_c & ~fault_c;
        end
    end

    always_comb begin
        bus_valid = 1'b0;
        bus_addr  = '0;
        bus_be_n  = '1;
        bus_split = 1'b0;
        bus_fault = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ONE: begin
                bus_valid = 1'b1;
                bus_addr  = addr_q;
                bus_be_n  = be1_q;
                bus_split = split_q;
            end
            ST_TWO: begin
                bus_valid = 1'b1;
                bus_addr  = addr_q + WA_W'(1);
                bus_be_n  = be2_q;
                bus_split = 1'b1;
            end
            ST_FLT: bus_fault = 1'b1;
        endcase
    end
endmodule

// File: rtl/agu_checker.sv
module agu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        bus_valid,
    input logic [29:0] bus_addr,
    input logic [3:0]  bus_be_n,
    input logic        bus_split,
    input logic        bus_fault
);
    a_r9_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !req_ready) |=> (bus_valid && bus_split && req_ready
                                       && bus_addr == $past(bus_addr) + 30'd1));

    a_r9_stall_only_first: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (bus_valid && bus_split));

    a_r8_some_lane: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_be_n != 4'hF));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (bus_be_n == 4'hF && bus_addr == 30'd0 && !bus_split));

    a_r5_fault_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fault |-> !bus_valid);

    a_r5_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fault |-> req_ready);
endmodule

bind agu_top agu_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_be_n  (bus_be_n),
    .bus_split (bus_split),
    .bus_fault (bus_fault)
);

// File: tb/agu_top_tb_top.sv
module agu_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_prot = 0, req_paging = 0;
    logic [15:0] req_selector = '0;
    logic        req_base_en = 0, req_index_en = 0;
    logic [31:0] req_base = '0, req_index = '0, req_disp = '0;
    logic [1:0]  req_scale = '0, req_size = '0;
    logic [19:0] req_frame = '0;
    logic        tbl_we = 0;
    logic [2:0]  tbl_idx = '0;
    logic [31:0] tbl_base = '0;
    logic        req_ready, bus_valid, bus_split, bus_fault;
    logic [29:0] bus_addr;
    logic [3:0]  bus_be_n;

    always #10 clk = ~clk;

    agu_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_prot(req_prot), .req_paging(req_paging), .req_selector(req_selector),
        .req_base_en(req_base_en), .req_base(req_base), .req_index_en(req_index_en),
        .req_index(req_index), .req_scale(req_scale), .req_disp(req_disp),
        .req_size(req_size), .req_frame(req_frame), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_base(tbl_base), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_split(bus_split),
        .bus_fault(bus_fault)
    );

    typedef struct packed {
        logic        v;
        logic [29:0] a;
        logic [3:0]  be;
        logic        sp;
        logic        f;
    } beat_t;

    localparam beat_t IDLE_B = '{v: 1'b0, a: 30'd0, be: 4'hF, sp: 1'b0, f: 1'b0};

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string scen = "R1";
    beat_t q[$];
    beat_t cur = IDLE_B;
    logic [31:0] m_base [8];
    bit          m_ld   [8];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s]: actual %h expected %h", tag, scen, act, exp);
        end
    endtask

    function automatic void model_accept();
        logic [31:0] off, lin, phys;
        logic [7:0]  span;
        int          n;
        beat_t       b1, b2;
        bit          flt;
        off = (req_base_en ? req_base : 32'd0)
            + (req_index_en ? (req_index * (32'd1 << req_scale)) : 32'd0)
            + req_disp;
        if (req_prot) begin
            lin = m_base[req_selector[5:3]] + off;
            flt = !m_ld[req_selector[5:3]];
        end else begin
            lin = {12'd0, req_selector, 4'd0} + off;
            flt = 0;
        end
        phys = req_paging ? {req_frame, lin[11:0]} : lin;
        n = (req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4;
        span = 8'(((1 << n) - 1) << lin[1:0]);
        if (flt) begin
            b1 = IDLE_B; b1.f = 1'b1;
            q.push_back(b1);
        end else begin
            b1 = '{v: 1'b1, a: phys[31:2], be: ~span[3:0], sp: (span[7:4] != 0), f: 1'b0};
            q.push_back(b1);
            if (span[7:4] != 0) begin
                b2 = '{v: 1'b1, a: phys[31:2] + 30'd1, be: ~span[7:4], sp: 1'b1, f: 1'b0};
                q.push_back(b2);
            end
        end
    endfunction

    task automatic tick();
        bit rdy;
        rdy = (q.size() == 0);
        @(posedge clk);
        if (rst_n && req_valid && rdy) model_accept();
        if (rst_n && tbl_we) begin
            m_base[tbl_idx] = tbl_base;
            m_ld[tbl_idx]   = 1'b1;
        end
        cur = (q.size() != 0) ? q.pop_front() : IDLE_B;
        @(negedge clk);
        chk("R7 valid", 32'(bus_valid), 32'(cur.v));
        chk("R7 addr (R2/R3/R4/R6 path)", 32'(bus_addr), 32'(cur.a));
        chk("R8 byte enables", 32'(bus_be_n), 32'(cur.be));
        chk("R9 split", 32'(bus_split), 32'(cur.sp));
        chk("R5 fault", 32'(bus_fault), 32'(cur.f));
        chk("R9 ready", 32'(req_ready), 32'(q.size() == 0));
        req_valid = 0;
        tbl_we    = 0;
    endtask

    task automatic req(bit prot, bit pg, logic [15:0] sel, bit be, logic [31:0] b,
                       bit ie, logic [31:0] ix, logic [1:0] sc, logic [31:0] d,
                       logic [1:0] sz, logic [19:0] fr);
        req_valid = 1; req_prot = prot; req_paging = pg; req_selector = sel;
        req_base_en = be; req_base = b; req_index_en = ie; req_index = ix;
        req_scale = sc; req_disp = d; req_size = sz; req_frame = fr;
    endtask

    task automatic twrite(logic [2:0] i, logic [31:0] b);
        tbl_we = 1; tbl_idx = i; tbl_base = b;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_base[i] = '0; m_ld[i] = 0; end
        repeat (3) @(negedge clk);
        scen = "R1 reset";
        chk("R1 valid", 32'(bus_valid), 0);
        chk("R1 fault", 32'(bus_fault), 0);
        chk("R1 be_n", 32'(bus_be_n), 32'hF);
        chk("R1 ready", 32'(req_ready), 1);
        chk("R1 addr", 32'(bus_addr), 0);
        rst_n = 1;
        @(negedge clk);

        scen = "R2 components";
        req(0,0,16'h0,1,32'h100,1,32'h3,2'd2,32'h20,2'd2,20'h0); tick();
        chk("R2 offset addr", 32'(bus_addr), 32'h4B);
        for (int sc = 0; sc < 4; sc++) begin
            req(0,0,16'h0,0,32'hFFFF,1,32'h10,2'(sc),32'h0,2'd0,20'h0); tick();
        end
        req(0,0,16'h0,1,32'hFFFF_FFFC,0,32'h55,2'd3,32'h8,2'd2,20'h0); tick();
        chk("R2 wrap addr", 32'(bus_addr), 32'h1);

        scen = "R3 real mode";
        req(0,0,16'h1234,0,0,0,0,2'd0,32'h0005,2'd0,20'h0); tick();
        chk("R3 real addr", 32'(bus_addr), 32'((32'h12345) >> 2));
        chk("R8 lane1", 32'(bus_be_n), 32'hD);

        scen = "R5 unloaded";
        req(1,0,16'h0008,0,0,0,0,2'd0,32'h0,2'd2,20'h0); tick();
        chk("R5 pulse", 32'(bus_fault), 1);
        tick();
        chk("R5 one cycle", 32'(bus_fault), 0);

        scen = "R4 same-edge write";
        twrite(3'd1, 32'h0001_0000);
        req(1,0,16'h0008,0,0,0,0,2'd0,32'h40,2'd2,20'h0); tick();
        chk("R4 old entry faults", 32'(bus_fault), 1);
        req(1,0,16'h0008,0,0,0,0,2'd0,32'h40,2'd2,20'h0); tick();
        chk("R4 base used", 32'(bus_addr), 32'(32'h0001_0040 >> 2));

        scen = "R6 paging";
        req(1,1,16'h0008,0,0,0,0,2'd0,32'h0ABC,2'd0,20'hFEDCB); tick();
        chk("R6 frame", 32'(bus_addr), 32'(32'hFEDC_BABC >> 2));

        scen = "R9 split";
        req(0,0,16'h0,0,0,0,0,2'd0,32'h0000_0103,2'd2,20'h0); tick();
        chk("R9 first be", 32'(bus_be_n), 32'h7);
        tick();
        chk("R9 second be", 32'(bus_be_n), 32'h8);
        chk("R9 second addr", 32'(bus_addr), 32'h41);
        req(0,0,16'h0,0,0,0,0,2'd0,32'hFFFF_FFFF,2'd1,20'h0); tick(); tick();
        chk("R9 wrap addr", 32'(bus_addr), 0);

        scen = "R8 all sizes/offsets";
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++) begin
                req(0,0,16'h0,0,0,0,0,2'd0,32'(32'h200 + o),2'(s),20'h0); tick();
            end

        scen = "random";
        for (int k = 0; k < 8; k += 2) begin twrite(3'(k), $urandom); tick(); end
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 3) != 0)
                req($urandom_range(0,1), $urandom_range(0,1), 16'($urandom),
                    $urandom_range(0,1), $urandom, $urandom_range(0,1), $urandom,
                    2'($urandom), $urandom, 2'($urandom), 20'($urandom));
            if ($urandom_range(0, 15) == 0) twrite(3'($urandom), $urandom);
            tick();
        end
        tick(); tick();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule